// File: doc/BRIEF.md
# Double-Buffered Serial DAC Command Interface

This block is the digital front end of a voltage-output converter. A host sends 16-bit command words over a three-wire link made of an active-low chip select, a serial clock and a serial data line. When chip select rises after a complete word, the block decodes a 4-bit control prefix. The prefix either loads a staging register (the input latch), copies the input latch into the register that drives the converter (the DAC latch), or does both at once. The DAC latch presents a code of parameterized width (12, 10 or 8 bits) to the analog side.

All three serial pins are brought into a faster system clock domain through synchronizer chains. Serial clock rising edges and chip select edges are detected in that domain. A one-cycle strobe marks each change of the DAC latch, so downstream logic can time converter settling from it.

Top module: `serial_dac_front`

## Requirements
- R1: A frame is 16 bits, sent most significant bit first. Bits 15..12 are the control field and bits 11..0 are the data field.
- R2: A data bit is taken only on a rising edge of sck_i while cs_ni is low. sck_i and sdi_i activity while cs_ni is high has no effect on the frame. Each sck_i level must be held for at least three clk_i cycles.
- R3: A frame is accepted only when cs_ni rises after exactly 16 sck_i rising edges counted since cs_ni fell. With any other count, both latches keep their values.
- R4: Control value 4'h0 loads the data field into the input latch and leaves code_o unchanged.
- R5: Control value 4'h1 copies the input latch into the DAC latch and ignores the data field of the same word.
- R6: Control value 4'h2 loads the data field into both the input latch and the DAC latch.
- R7: Every control value from 4'h3 to 4'hF leaves both latches unchanged.
- R8: When CODE_W is below 12, the code is the upper CODE_W bits of the data field, and the lower bits are ignored.
- R9: After rst_ni is asserted, both latches are zero, code_o is zero and dac_updated_o is low.
- R10: For an accepted update command (R5, R6), code_o takes its new value, and dac_updated_o is high for exactly one cycle, on the fourth rising clk_i edge that samples cs_ni high. For every other frame, dac_updated_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than sck_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| code_o | output | CODE_W | DAC latch contents driven to the converter |
| dac_updated_o | output | 1 | One-cycle strobe when the DAC latch is written |

## Verification
The bench drives two instances from the same serial pins. One uses the full 12-bit code and the other uses CODE_W = 8. The 12-bit instance exercises every data bit end to end. The 8-bit instance shows that the low four data bits are dropped and that the code comes from the upper bits. Both are compared against a behavioural latch model on every clock, through the latency window after each chip select rise, for load, update, combined, no-op, short and long frames.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int FRAME_W = 16;
  localparam int CTRL_W  = 4;
  localparam int DATA_W  = FRAME_W - CTRL_W;

  typedef enum logic [CTRL_W-1:0] {
    CTRL_LOAD     = 4'h0,
    CTRL_UPDATE   = 4'h1,
    CTRL_LOAD_UPD = 4'h2
  } dac_ctrl_e;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dac_shifter.sv
module dac_shifter
  import dac_if_pkg::*;
#(
  parameter int KEEP_W = FRAME_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  output logic              frame_stb_o,
  output logic [KEEP_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic               cs_q, sck_q;
  logic               cs_rise, cs_fall, sck_rise;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  assign cs_rise  = cs_s_i & ~cs_q;
  assign cs_fall  = ~cs_s_i & cs_q;
  assign sck_rise = sck_s_i & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q        <= 1'b1;
      sck_q       <= 1'b0;
      shreg       <= '0;
      cnt         <= '0;
      frame_stb_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      cs_q  <= cs_s_i;
      sck_q <= sck_s_i;
      if (cs_fall) begin
        cnt <= '0;
      end else if (sck_rise && !cs_s_i) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s_i};
        if (cnt <= CNT_W'(FRAME_W)) cnt <= cnt + 1'b1; // saturate above a full frame
      end
      frame_stb_o <= cs_rise && (cnt == CNT_W'(FRAME_W));
      if (cs_rise) frame_o <= shreg[FRAME_W-1 -: KEEP_W];
    end
  end

  assert_no_shift_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> $stable(shreg));
  assert_full_frame_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> $past(cnt) == CNT_W'(FRAME_W));
  assert_stb_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |=> !frame_stb_o);
endmodule

// File: rtl/dac_latches.sv
module dac_latches
  import dac_if_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int KEEP_W = CTRL_W + CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_stb_i,
  input  logic [KEEP_W-1:0] frame_i,
  output logic [CODE_W-1:0] code_o,
  output logic              dac_updated_o
);
  dac_ctrl_e         ctrl;
  logic [CODE_W-1:0] data, in_latch;

  assign ctrl = dac_ctrl_e'(frame_i[KEEP_W-1 -: CTRL_W]);
  assign data = frame_i[CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_latch      <= '0;
      code_o        <= '0;
      dac_updated_o <= 1'b0;
    end else begin
      dac_updated_o <= 1'b0;
      if (frame_stb_i) begin
        case (ctrl)
          CTRL_LOAD: in_latch <= data;
          CTRL_UPDATE: begin
            code_o        <= in_latch;
            dac_updated_o <= 1'b1;
          end
          CTRL_LOAD_UPD: begin
            in_latch      <= data;
            code_o        <= data;
            dac_updated_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_load_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && ctrl == CTRL_LOAD) |=> ($stable(code_o) && !dac_updated_o));
  assert_update_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && ctrl == CTRL_UPDATE) |=> (code_o == $past(in_latch) && $stable(in_latch)));
  assert_load_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && ctrl == CTRL_LOAD_UPD) |=> (code_o == in_latch));
  assert_noop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && frame_i[KEEP_W-1 -: CTRL_W] > 4'h2) |=> ($stable(in_latch) && $stable(code_o)));
  assert_strobe_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_updated_o |-> $past(frame_stb_i));
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import dac_if_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic              dac_updated_o
);
  localparam int KEEP_W = CTRL_W + CODE_W;

  logic [2:0]        pins_s;
  logic              frame_stb;
  logic [KEEP_W-1:0] frame;

  dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .q_o   (pins_s)
  );

  dac_shifter #(.KEEP_W(KEEP_W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (pins_s[2]),
    .sck_s_i    (pins_s[1]),
    .sdi_s_i    (pins_s[0]),
    .frame_stb_o(frame_stb),
    .frame_o    (frame)
  );

  dac_latches #(.CODE_W(CODE_W), .KEEP_W(KEEP_W)) u_latches (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_stb_i  (frame_stb),
    .frame_i      (frame),
    .code_o       (code_o),
    .dac_updated_o(dac_updated_o)
  );
endmodule

// File: tb/serial_dac_front_bench.sv
module serial_dac_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [11:0] code12;
  logic [7:0]  code8;
  logic        upd12, upd8;

  int vectors = 0, fails = 0;
  int model_in = 0, model_dac = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_dac_front #(.CODE_W(12)) u_serial_dac_front (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .code_o(code12), .dac_updated_o(upd12));

  serial_dac_front #(.CODE_W(8)) u_serial_dac_front_w8 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .code_o(code8), .dac_updated_o(upd8));

  task automatic check(string req, int dac, bit stb);
    vectors++;
    if (code12 !== 12'(dac) || upd12 !== stb) begin
      fails++;
      $display("FAIL %s w12: code=%h upd=%b expected code=%h upd=%b", req, code12, upd12, 12'(dac), stb);
    end
    vectors++;
    if (code8 !== 8'(dac >> 4) || upd8 !== stb) begin
      fails++;
      $display("FAIL %s/R8 w8: code=%h upd=%b expected code=%h upd=%b", req, code8, upd8, 8'(dac >> 4), stb);
    end
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, model_dac, 1'b0);
    end
  endtask

  // Sends nclk bits of {ctrl,data} MSB first (zeros past bit 16), then raises cs.
  task automatic frame(int ctrl, int data, int nclk, string req);
    logic [15:0] word = {4'(ctrl), 12'(data)};
    int old_dac = model_dac;
    bit upd = 0;
    cs_n = 1'b0;
    idle(HOLD, req);
    for (int b = 0; b < nclk; b++) begin
      sdi = (b < 16) ? word[15-b] : 1'b0;
      idle(HOLD, req);
      sck = 1'b1;
      idle(HOLD, req);
      sck = 1'b0;
    end
    idle(HOLD, req);
    cs_n = 1'b1;
    if (nclk == 16) begin
      case (ctrl)
        0: model_in = data & 12'hFFF;
        1: begin model_dac = model_in; upd = 1; end
        2: begin model_in = data & 12'hFFF; model_dac = model_in; upd = 1; end
        default: ;
      endcase
    end
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k < 4) check({req, "/R10 pre"}, old_dac, 1'b0);
      else if (k == 4) check({req, "/R10 edge"}, model_dac, upd);
      else check({req, "/R10 post"}, model_dac, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 0, 1'b0);
    rst_n = 1'b1;
    idle(4, "R9 after reset");
    frame(0, 12'hABC, 16, "R4 load only");
    frame(1, 12'hFFF, 16, "R5 update ignores data");
    frame(2, 12'h123, 16, "R6 load and update");
    frame(0, 12'h456, 16, "R4 load");
    frame(5, 12'h999, 16, "R7 noop 5");
    frame(4'hF, 12'h777, 16, "R7 noop F");
    frame(3, 12'h111, 16, "R7 noop 3");
    frame(1, 12'h000, 16, "R5 R7 update shows input kept");
    frame(2, 12'h3A5, 15, "R3 short frame");
    frame(2, 12'h3A5, 17, "R3 long frame");
    // sck/sdi toggling with cs high must not disturb anything
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sck = 1'b1;
      idle(HOLD, "R2 idle clocks");
      sck = 1'b0;
      idle(HOLD, "R2 idle clocks");
    end
    frame(1, 12'h000, 16, "R2 update after idle clocks");
    frame(2, 12'hFFF, 16, "R1 all ones");
    frame(2, 12'h000, 16, "R1 all zeros");
    frame(2, 12'h80F, 16, "R1 R8 msb and low bits");
    frame(2, 12'hABF, 16, "R8 upper bits");
    frame(0, 12'h5A0, 16, "R4 load");
    frame(2, 12'h001, 16, "R6 overrides");
    frame(1, 12'hEEE, 16, "R5 copies latest load");
    idle(5, "R10 quiet");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule